// File: doc/BRIEF.md
# Late-Write Pipelined Single-Port Memory

This block is a synchronous single-port memory that speaks a late-write protocol. A write is presented in two parts. The address, the byte-lane enables and the control come in one cycle, and the data for that write comes on the bus in the following cycle. Each write is posted into a one-deep holding buffer. The array itself is updated from that buffer only when the next write's data phase arrives. Because of this, a read can be issued in the cycle just before a write, and no idle cycle is needed on a shared data bus.

Reads are registered, with a latency of one clock. Each read address is compared per byte lane against two sources: the write whose data is arriving in that same cycle, and the posted buffer. Lanes that match are taken from the newest source, and the remaining lanes come from the array. When the output is not driving, it shows a zero word and the drive indication is low. This covers deselected cycles, write cycles and sleep. A high sleep input blocks all new accesses and leaves the array contents unchanged.

Top module: `lwsram`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rdDrive` is 0 and `rdData` is all zeros. The posted buffer starts empty, so no forwarding happens before the first write.
- R2: A read is accepted in a cycle where `chipSel`=1, `wrEn`=0 and `sleep`=0. On the next clock, `rdDrive` goes to 1 and `rdData` holds the word at that address.
- R3: A write is accepted in a cycle where `chipSel`=1, `wrEn`=1 and `sleep`=0. Its data is taken from `wrData` in the following cycle, and `rdDrive` is 0 in the cycle after the write.
- R4: A posted write moves into the array when the next write's data arrives. After several further writes to other addresses, reading the earlier address returns its data.
- R5: Byte lane i covers bits [9i+8:9i]. After a partial write, a read of that address returns the written lanes from the buffer and all other lanes from the array.
- R6: A read followed at once by a write needs no idle cycle between them, and both return correct results.
- R7: A read issued in the data cycle of a write to the same address returns the new data for the enabled lanes.
- R8: In a cycle with `chipSel`=0, no access takes place. `rdDrive` is 0 in the next cycle, and a write request made while deselected leaves the memory unchanged.
- R9: In a cycle with `sleep`=1, no access is accepted and `rdDrive` is 0 in the next cycle. Data written before sleep reads back unchanged after sleep ends.
- R10: A write with `byteWe`=0 leaves the stored word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| chipSel | input | 1 | Cycle select; 0 makes the cycle idle |
| wrEn | input | 1 | 1 = write request, 0 = read request |
| byteWe | input | 2 | Per-lane write enables for the write request |
| addr | input | 6 | Word address of the request |
| wrData | input | 18 | Data of the write requested in the previous cycle |
| sleep | input | 1 | Blocks new accesses and forces the output idle |
| rdData | output | 18 | Read word; zero when not driving |
| rdDrive | output | 1 | 1 when `rdData` carries read data, 0 for High-Z |

## Verification
The block is exercised with several sequences. Full-word writes followed by reads of older addresses show whether a posted write reaches the array. Partial writes on top of full words separate lanes that come from the buffer from lanes that come from the array. A read placed in a write's data cycle shows whether incoming data is forwarded. Reads interleaved directly with writes confirm that no turnaround cycle is needed. Deselected write requests, zero-enable writes and sleep windows are each followed by reads, which show that those cycles left the memory contents unchanged.

// File: rtl/lwsram_pkg.sv
package lwsram_pkg;
  // Strobes from control to datapath for one clock
  typedef struct packed {
    logic dataPhase;  // data of the previously accepted write is on wrData
    logic readNow;    // a read is accepted this cycle
  } ctlStrobe_t;
endpackage

// File: rtl/lwsram_ctrl.sv
module lwsram_ctrl
  import lwsram_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chipSel,
  input  logic             wrEn,
  input  logic [LANES-1:0] byteWe,
  input  logic [AW-1:0]    addr,
  input  logic             sleep,
  output ctlStrobe_t       strobe,
  output logic [AW-1:0]    pendAddr,
  output logic [LANES-1:0] pendBe
);
  logic accept;
  logic wrAccept;
  logic pendValid;

  assign accept   = chipSel & ~sleep;
  assign wrAccept = accept & wrEn;

  // Address phase of a write is held one cycle until its data arrives
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendAddr  <= '0;
      pendBe    <= '0;
    end else begin
      pendValid <= wrAccept;
      if (wrAccept) begin
        pendAddr <= addr;
        pendBe   <= byteWe;
      end
    end
  end

  always_comb begin
    strobe.dataPhase = pendValid;
    strobe.readNow   = accept & ~wrEn;
  end
endmodule

// File: rtl/lwsram_dpath.sv
module lwsram_dpath
  import lwsram_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int LANES = 2,
  parameter int BW    = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          strobe,
  input  logic [AW-1:0]       pendAddr,
  input  logic [LANES-1:0]    pendBe,
  input  logic [AW-1:0]       readAddr,
  input  logic [LANES*BW-1:0] wrData,
  output logic [LANES*BW-1:0] rdData,
  output logic                rdDrive
);
  localparam int WORD = LANES * BW;

  logic [WORD-1:0] mem [DEPTH];

  logic                      bufValid;
  logic [AW-1:0]             bufAddr;
  logic [LANES-1:0]          bufBe;
  logic [LANES-1:0][BW-1:0]  bufLanes;
  logic [LANES-1:0][BW-1:0]  inLanes;
  logic [LANES-1:0][BW-1:0]  arrLanes;
  logic [LANES-1:0][BW-1:0]  mergedLanes;
  logic [WORD-1:0]           rdReg;
  logic                      driveReg;
  logic                      hitIn;
  logic                      hitBuf;

  assign inLanes  = wrData;
  assign arrLanes = mem[readAddr];
  assign hitIn    = strobe.dataPhase && (pendAddr == readAddr);
  assign hitBuf   = bufValid && (bufAddr == readAddr);

  // Commit the posted write into the array when the next write's data arrives
  always_ff @(posedge clk) begin
    if (strobe.dataPhase && bufValid) begin
      for (int i = 0; i < LANES; i++) begin
        if (bufBe[i]) mem[bufAddr][i*BW +: BW] <= bufLanes[i];
      end
    end
  end

  // Holding buffer takes the newest write
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufValid <= 1'b0;
      bufAddr  <= '0;
      bufBe    <= '0;
      bufLanes <= '0;
    end else if (strobe.dataPhase) begin
      bufValid <= 1'b1;
      bufAddr  <= pendAddr;
      bufBe    <= pendBe;
      bufLanes <= inLanes;
    end
  end

  // Per-lane source choice: incoming data, then buffer, then array
  for (genvar g = 0; g < LANES; g++) begin : gLane
    always_comb begin
      if (hitIn && pendBe[g])        mergedLanes[g] = inLanes[g];
      else if (hitBuf && bufBe[g])   mergedLanes[g] = bufLanes[g];
      else                           mergedLanes[g] = arrLanes[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdReg    <= '0;
      driveReg <= 1'b0;
    end else begin
      driveReg <= strobe.readNow;
      if (strobe.readNow) rdReg <= mergedLanes;
    end
  end

  assign rdDrive = driveReg;
  assign rdData  = driveReg ? rdReg : '0;
endmodule

// File: rtl/lwsram.sv
module lwsram
  import lwsram_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LANES = 2,
  parameter int BW    = 9,
  localparam int AW   = $clog2(DEPTH),
  localparam int WORD = LANES * BW
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chipSel,
  input  logic             wrEn,
  input  logic [LANES-1:0] byteWe,
  input  logic [AW-1:0]    addr,
  input  logic [WORD-1:0]  wrData,
  input  logic             sleep,
  output logic [WORD-1:0]  rdData,
  output logic             rdDrive
);
  ctlStrobe_t       strobe;
  logic [AW-1:0]    pendAddr;
  logic [LANES-1:0] pendBe;

  lwsram_ctrl #(.AW(AW), .LANES(LANES)) u_ctrl (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .wrEn(wrEn),
    .byteWe(byteWe), .addr(addr), .sleep(sleep),
    .strobe(strobe), .pendAddr(pendAddr), .pendBe(pendBe)
  );

  lwsram_dpath #(.DEPTH(DEPTH), .AW(AW), .LANES(LANES), .BW(BW)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pendAddr(pendAddr),
    .pendBe(pendBe), .readAddr(addr), .wrData(wrData),
    .rdData(rdData), .rdDrive(rdDrive)
  );
endmodule

// File: rtl/lwsram_chk.sv
module lwsram_chk (
  input logic clk,
  input logic rstN,
  input logic chipSel,
  input logic wrEn,
  input logic sleep,
  input logic rdDrive
);
  // R2
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chipSel && !wrEn && !sleep) |=> rdDrive);

  // R3
  write_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chipSel && wrEn && !sleep) |=> !rdDrive);

  // R8
  deselect_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !chipSel |=> !rdDrive);

  // R9
  sleep_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleep |=> !rdDrive);
endmodule

bind lwsram lwsram_chk u_chk (
  .clk(clk), .rstN(rstN), .chipSel(chipSel), .wrEn(wrEn),
  .sleep(sleep), .rdDrive(rdDrive)
);

// File: tb/lwsram_bench.sv
module lwsram_bench;
  localparam int DEPTH = 64;
  localparam int AW    = 6;
  localparam int WORD  = 18;

  logic            clk = 1'b0;
  logic            rstN;
  logic            chipSel, wrEn, sleep;
  logic [1:0]      byteWe;
  logic [AW-1:0]   addr;
  logic [WORD-1:0] wrData;
  logic [WORD-1:0] rdData;
  logic            rdDrive;

  int tests = 0;
  int fails = 0;

  logic [WORD-1:0] model [DEPTH];
  logic [WORD-1:0] nextData;

  logic            expDriveQ [$];
  logic [WORD-1:0] expDataQ  [$];
  string           tagQ      [$];
  logic            monOn = 1'b0;

  always #10 clk = ~clk;

  lwsram u_lwsram (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .wrEn(wrEn),
    .byteWe(byteWe), .addr(addr), .wrData(wrData), .sleep(sleep),
    .rdData(rdData), .rdDrive(rdDrive)
  );

  // One cycle of stimulus; wrData carries the previous write's data
  task automatic cyc(input logic cs, input logic we, input logic [1:0] be,
                     input logic [AW-1:0] a, input logic [WORD-1:0] d,
                     input logic slp, input string tag);
    @(negedge clk);
    chipSel = cs; wrEn = we; byteWe = be; addr = a; sleep = slp;
    wrData  = nextData;
    nextData = 'x;
    if (cs && !slp && we) begin
      nextData = d;
      for (int i = 0; i < 2; i++)
        if (be[i]) model[a][i*9 +: 9] = d[i*9 +: 9];
      expDriveQ.push_back(1'b0); expDataQ.push_back('0);
    end else if (cs && !slp) begin
      expDriveQ.push_back(1'b1); expDataQ.push_back(model[a]);
    end else begin
      expDriveQ.push_back(1'b0); expDataQ.push_back('0);
    end
    tagQ.push_back(tag);
    monOn = 1'b1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [1:0] be,
                    input logic [WORD-1:0] d, input string tag);
    cyc(1'b1, 1'b1, be, a, d, 1'b0, tag);
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    cyc(1'b1, 1'b0, 2'b00, a, '0, 1'b0, tag);
  endtask

  task automatic idle(input string tag);
    cyc(1'b0, 1'b0, 2'b00, '0, '0, 1'b0, tag);
  endtask

  // Monitor: one scoreboard item per clock
  always @(posedge clk) begin
    #5;
    if (monOn && expDriveQ.size() > 0) begin
      logic            ed;
      logic [WORD-1:0] ex;
      string           tg;
      ed = expDriveQ.pop_front();
      ex = expDataQ.pop_front();
      tg = tagQ.pop_front();
      tests++;
      if (rdDrive !== ed || rdData !== ex) begin
        fails++;
        $display("FAIL %s: drive=%0b data=%h expected drive=%0b data=%h",
                 tg, rdDrive, rdData, ed, ex);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    nextData = 'x;
    rstN = 1'b0; chipSel = 1'b0; wrEn = 1'b0; byteWe = 2'b00;
    addr = '0; wrData = '0; sleep = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    tests++;
    if (rdDrive !== 1'b0 || rdData !== '0) begin
      fails++;
      $display("FAIL R1 reset: drive=%0b data=%h expected 0/0", rdDrive, rdData);
    end
    @(negedge clk); rstN = 1'b1;
    idle("R1 after reset");

    // R3/R2: full writes then reads of each
    wr(6'd1, 2'b11, 18'h12345, "R3 write a1");
    wr(6'd2, 2'b11, 18'h0ABCD, "R3 write a2");
    wr(6'd3, 2'b11, 18'h3C3C3, "R3 write a3");
    idle("R3 data phase");
    rd(6'd1, "R4 read a1 from array");
    rd(6'd2, "R4 read a2 from array");
    rd(6'd3, "R2 read a3 from buffer");

    // R5: partial write over a full word now in the array
    wr(6'd4, 2'b11, 18'h2AAAA, "R5 full a4");
    wr(6'd5, 2'b11, 18'h15555, "R5 full a5");
    wr(6'd4, 2'b01, 18'h000F0, "R5 low lane a4");
    idle("R5 data phase");
    rd(6'd4, "R5 merged low lane");
    wr(6'd4, 2'b10, 18'h3FE00, "R5 high lane a4");
    idle("R5 data phase 2");
    rd(6'd4, "R5 merged high lane");

    // R7: read in the write's data cycle, same address
    wr(6'd6, 2'b11, 18'h00777, "R7 write a6");
    rd(6'd6, "R7 forward incoming");
    wr(6'd6, 2'b10, 18'h1B000, "R7 partial a6");
    rd(6'd6, "R7 forward partial incoming");

    // R6: read then write with no gap, alternating
    rd(6'd1, "R6 read before write");
    wr(6'd7, 2'b11, 18'h24680, "R6 write after read");
    rd(6'd2, "R6 read in data cycle");
    wr(6'd8, 2'b11, 18'h13579, "R6 write again");
    rd(6'd7, "R6 read a7");
    rd(6'd8, "R6 read a8");

    // R8: deselected write request ignored
    cyc(1'b0, 1'b1, 2'b11, 6'd1, 18'h3FFFF, 1'b0, "R8 deselected write");
    idle("R8 deselect");
    rd(6'd1, "R8 a1 unchanged");

    // R10: zero-enable write
    wr(6'd2, 2'b00, 18'h11111, "R10 zero enable");
    idle("R10 data phase");
    rd(6'd2, "R10 a2 unchanged");
    wr(6'd9, 2'b11, 18'h00001, "R10 push commit");
    idle("R10 data phase 2");
    rd(6'd2, "R10 a2 after commit");

    // R9: sleep blocks accesses, contents kept
    cyc(1'b1, 1'b0, 2'b00, 6'd3, '0, 1'b1, "R9 read during sleep");
    cyc(1'b1, 1'b1, 2'b11, 6'd3, 18'h0DEAD, 1'b1, "R9 write during sleep");
    cyc(1'b0, 1'b0, 2'b00, 6'd0, '0, 1'b1, "R9 sleep idle");
    rd(6'd3, "R9 a3 kept");
    rd(6'd9, "R9 a9 kept");

    // R4: many later writes, then old addresses read back
    for (int k = 10; k < 20; k++)
      wr(AW'(k), 2'b11, WORD'(k * 18'h00421), "R4 bulk write");
    idle("R4 data phase");
    for (int k = 10; k < 20; k++) rd(AW'(k), "R4 bulk read");
    rd(6'd4, "R4 old a4");
    rd(6'd6, "R4 old a6");
    idle("tail");
    idle("tail");

    @(negedge clk);
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule